// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked static memory with a small array that is set by parameters. Address, chip select, write controls and write data are captured on the rising clock edge. Each sampled cycle is one of three commands: deselect, read or write. An external burst counter supplies the address, so the core only sees one word address per cycle. A static mode input sets the read latency. With the mode input low, read data goes past the output register (flow-through). With it high, read data passes through that register and arrives one cycle later (pipelined). Write data is stored in the array at the same edge that samples the write.

The core's access state machine holds the command accepted at the last edge, in one of three states. `ST_DESEL` is idle. `ST_READ` means a read is in flight. `ST_WRITE` means a write has been stored. From any state, each edge takes one of three transitions:
- `GO_DESEL`: chip select is low, or sleep is high.
- `GO_WRITE`: chip select is high and either the global write is set, or the byte-write enable is set with at least one lane selected.
- `GO_READ`: any other selected cycle.

A read-active flag follows this state into an enable pipeline that has the same depth as the read data. A deselect or write therefore reaches the outputs exactly when a read would have, which gives dual-cycle-deselect behaviour. The output-valid flag combines the pipelined enable with the active-low output enable and the sleep input, and both of those act without a clock. A read made while the output enable is high is a dummy read. It runs through the pipeline but drives nothing, so a write can follow it with no deselect cycle in between.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset is asserted (asynchronously, active low), `rvalid` is 0 until a read issued after reset reaches the output.
- R2: With `pipe_mode`=0, a read sampled at edge k presents the word on `rdata` with `rvalid`=1 after edge k+1 (first access in two cycles).
- R3: With `pipe_mode`=1, a read sampled at edge k presents the word after edge k+2 (first access in three cycles).
- R4: Reads on consecutive edges deliver one word per cycle, in issue order, in both modes.
- R5: Deselects and writes travel through the same pipeline depth as reads. After a deselect following a read, the last word stays valid for the full cycle and `rvalid` drops only when the deselect's slot reaches the output.
- R6: With `sel`=1, `glob_wr`=0 and `byte_wr`=1, lane i (bits i*LANE_W to i*LANE_W+LANE_W-1) is written only where `lane_sel[i]`=1. With `byte_wr`=1 and `lane_sel`=0, the cycle is a read and no lane changes.
- R7: With `sel`=1 and `glob_wr`=1, all lanes are written, whatever `byte_wr` and `lane_sel` hold.
- R8: `oe_n` gates `rvalid` without a clock. A read made while `oe_n`=1 still runs and can be seen if `oe_n` falls, and a write may follow it on the next edge.
- R9: While `sleep`=1, `rvalid` is 0 at once and sampled commands act as deselects; the array keeps its contents.
- R10: A write sampled on the edge after a read to the same word does not change the data returned by that read.
- R11: A read sampled on any edge after a write returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static mode: 1 pipelined, 0 flow-through |
| sleep | input | 1 | Asynchronous sleep, blocks access, keeps data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sel | input | 1 | Synchronous chip select |
| glob_wr | input | 1 | Write all lanes |
| byte_wr | input | 1 | Byte-write enable |
| lane_sel | input | LANES | Per-lane write selects |
| addr | input | AW | Word address from the burst counter |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, meaningful only when rvalid is 1 |
| rvalid | output | 1 | Read data valid |

## Verification
The array's read for an earlier read command and its write for a newer write command can land on the same clock edge. The bench sets this up by issuing a write to a word on the edge right after a read of that same word. It judges the result by requiring the earlier read to return the old word and a later read to return the new one. A second overlap occurs when a deselect enters the enable pipeline while the last read word is still being shown. This is judged cycle by cycle against the expected hold and turn-off points in both modes.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
    // Access state: the command accepted at the most recent edge
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_st_t;
endpackage

// File: rtl/sbs_cmd_decode.sv
`timescale 1ns/1ps
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel,
    input  logic             sleep,
    input  logic             glob_wr,
    input  logic             byte_wr,
    input  logic [LANES-1:0] lane_sel,
    output acc_st_t          nxt_cmd,
    output logic [LANES-1:0] wr_lanes
);
    logic wr_req;

    assign wr_req = glob_wr || (byte_wr && (|lane_sel));

    // Transition choice: GO_DESEL, GO_WRITE, GO_READ
    always_comb begin
        if (!sel || sleep) begin
            nxt_cmd = ST_DESEL;
        end else if (wr_req) begin
            nxt_cmd = ST_WRITE;
        end else begin
            nxt_cmd = ST_READ;
        end
    end

    // Lane enables for the write performed at this edge
    always_comb begin
        wr_lanes = '0;
        unique case (nxt_cmd)
            ST_WRITE: wr_lanes = glob_wr ? {LANES{1'b1}} : lane_sel;
            ST_READ:  wr_lanes = '0;
            ST_DESEL: wr_lanes = '0;
            default:  wr_lanes = '0;
        endcase
    end
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wdata,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rdata
);
    // One storage column per byte lane, each with its own write enable
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) begin
                mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                rd_q <= mem[rd_addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sbs_out_pipe.sv
`timescale 1ns/1ps
module sbs_out_pipe #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic          rd_active,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic          en_arr;   // slot aligned with the array read register
    logic          en_out;   // slot aligned with the output register
    logic [DW-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_arr <= 1'b0;
            en_out <= 1'b0;
        end else begin
            en_arr <= rd_active;
            en_out <= en_arr;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= arr_data;
    end

    logic slot_on;
    assign slot_on = pipe_mode ? en_out : en_arr;
    assign rdata   = pipe_mode ? out_q : arr_data;
    assign rvalid  = slot_on && !oe_n && !sleep;

    // R2: in flow-through mode, no valid data one edge after a non-read slot
    p_flow_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && $past(!rd_active)) |-> !rvalid);

    // R3: the output slot turns on only two edges after a read was in flight
    p_pipe_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_out) |-> $past(rd_active, 2));

    // R5: a deselect or write occupies the output slot as deep as a read
    p_desel_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(!rd_active, 2)) |-> !rvalid);
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_mode,
    input  logic             sleep,
    input  logic             oe_n,
    input  logic             sel,
    input  logic             glob_wr,
    input  logic             byte_wr,
    input  logic [LANES-1:0] lane_sel,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    acc_st_t          nxt_cmd;
    acc_st_t          st_q;
    logic [LANES-1:0] wr_lanes;
    logic [AW-1:0]    addr_q;
    logic             rd_active;
    logic [DW-1:0]    arr_data;

    sbs_cmd_decode #(.LANES(LANES)) u_dec (
        .sel      (sel),
        .sleep    (sleep),
        .glob_wr  (glob_wr),
        .byte_wr  (byte_wr),
        .lane_sel (lane_sel),
        .nxt_cmd  (nxt_cmd),
        .wr_lanes (wr_lanes)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_DESEL;
        end else begin
            st_q <= nxt_cmd;
        end
    end

    // Captured read address
    always_ff @(posedge clk) begin
        if (nxt_cmd == ST_READ) begin
            addr_q <= addr;
        end
    end

    // State outputs
    always_comb begin
        rd_active = 1'b0;
        unique case (st_q)
            ST_READ:  rd_active = 1'b1;
            ST_WRITE: rd_active = 1'b0;
            ST_DESEL: rd_active = 1'b0;
            default:  rd_active = 1'b0;
        endcase
    end

    sbs_array #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) u_arr (
        .clk      (clk),
        .wr_lanes (wr_lanes),
        .wr_addr  (addr),
        .wdata    (wdata),
        .rd_en    (rd_active),
        .rd_addr  (addr_q),
        .rdata    (arr_data)
    );

    sbs_out_pipe #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .rd_active (rd_active),
        .arr_data  (arr_data),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    // R7: a global write enables every lane
    p_glob_all_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && glob_wr && !sleep) |-> (&wr_lanes));

    // R6: a byte write enables exactly the selected lanes
    p_byte_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !glob_wr && byte_wr && !sleep) |-> (wr_lanes == lane_sel));

    // R9: a command sampled during sleep writes nothing and leaves the core idle
    p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ((wr_lanes == '0) ##1 (st_q == ST_DESEL)));
endmodule

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
    localparam int LW = 9;
    localparam int NL = 4;
    localparam int DP = 256;
    localparam int AW = $clog2(DP);
    localparam int DW = LW * NL;

    typedef struct packed {
        logic          sel;
        logic          glob;
        logic          bwe;
        logic [NL-1:0] lanes;
        logic [AW-1:0] adr;
        logic [DW-1:0] wd;
        logic          ev;
        logic [DW-1:0] ed;
    } vec_t;

    localparam logic [DW-1:0] A1   = {9'h011, 9'h022, 9'h033, 9'h044};
    localparam logic [DW-1:0] B1   = {9'h011, 9'h1AA, 9'h033, 9'h1AA};
    localparam logic [DW-1:0] A2   = {9'h101, 9'h0A0, 9'h0B0, 9'h0C0};
    localparam logic [DW-1:0] A3   = {9'h0F0, 9'h00F, 9'h155, 9'h0AA};
    localparam logic [DW-1:0] WA   = {4{9'h1AA}};
    localparam logic [DW-1:0] ONES = {DW{1'b1}};
    localparam logic [DW-1:0] ZD   = '0;

    // Flow-through mode; expected output is checked before the row is driven
    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 4'b0000, 8'd1, A1,   1'b0, ZD}, // R7 global write
        '{1'b1, 1'b1, 1'b1, 4'b0001, 8'd2, A2,   1'b0, ZD}, // R7 global overrides lanes
        '{1'b1, 1'b0, 1'b1, 4'b0101, 8'd1, WA,   1'b0, ZD}, // R6 lanes 0 and 2
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'd1, ZD,   1'b0, ZD}, // read 1
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'd2, ZD,   1'b0, ZD}, // read 2
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b1, B1}, // R2 latency, R6 merge
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b1, A2}, // R4, R7 full word
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'd2, ZD,   1'b0, ZD}, // R5 deselect slot
        '{1'b1, 1'b1, 1'b0, 4'b0000, 8'd2, A3,   1'b0, ZD}, // write right after read
        '{1'b1, 1'b0, 1'b0, 4'b0000, 8'd2, ZD,   1'b1, A2}, // R10 old data
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b0, ZD}, // write slot empty
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b1, A3}, // R11 new data
        '{1'b1, 1'b0, 1'b1, 4'b0000, 8'd2, ONES, 1'b0, ZD}, // R6 no lanes -> read
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b0, ZD},
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b1, A3}, // R6 word unchanged
        '{1'b0, 1'b0, 1'b0, 4'b0000, 8'd0, ZD,   1'b0, ZD}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          sleep = 1'b0;
    logic          oe_n = 1'b0;
    logic          sel = 1'b0;
    logic          glob_wr = 1'b0;
    logic          byte_wr = 1'b0;
    logic [NL-1:0] lane_sel = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.LANE_W(LW), .LANES(NL), .DEPTH(DP)) u_sync_burst_sram (
        .clk, .rst_n, .pipe_mode, .sleep, .oe_n, .sel, .glob_wr, .byte_wr,
        .lane_sel, .addr, .wdata, .rdata, .rvalid
    );

    task automatic chk(input string req, input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (rvalid !== ev || (ev && rdata !== ed)) begin
            failures++;
            $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                     req, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic drv(input logic s, input logic g, input logic b,
                       input logic [NL-1:0] l, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        sel = s; glob_wr = g; byte_wr = b; lane_sel = l; addr = a; wdata = d;
    endtask

    task automatic idle();
        drv(1'b0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 after reset", 1'b0, ZD);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk($sformatf("R2 R4 R5 R6 R7 R10 R11 table row %0d", i), TBL[i].ev, TBL[i].ed);
            drv(TBL[i].sel, TBL[i].glob, TBL[i].bwe, TBL[i].lanes, TBL[i].adr, TBL[i].wd);
        end

        // Pipelined mode: latency, streaming, deselect hold
        @(negedge clk); idle(); pipe_mode = 1'b1;
        repeat (3) @(negedge clk);
        drv(1'b1, 1'b0, 1'b0, '0, 8'd1, ZD);
        @(negedge clk); chk("R3 before data", 1'b0, ZD); drv(1'b1, 1'b0, 1'b0, '0, 8'd2, ZD);
        @(negedge clk); chk("R3 before data", 1'b0, ZD); drv(1'b1, 1'b0, 1'b0, '0, 8'd1, ZD);
        @(negedge clk); chk("R3 first word", 1'b1, B1); idle();
        @(negedge clk); chk("R4 second word", 1'b1, A3);
        @(negedge clk); chk("R5 held after deselect", 1'b1, B1);
        @(negedge clk); chk("R5 off at deselect slot", 1'b0, ZD);

        // Output enable: dummy read then write with no deselect
        pipe_mode = 1'b0;
        repeat (2) @(negedge clk);
        oe_n = 1'b1; drv(1'b1, 1'b0, 1'b0, '0, 8'd1, ZD);
        @(negedge clk); drv(1'b1, 1'b1, 1'b0, '0, 8'd3, A1);
        @(negedge clk); chk("R8 dummy read hidden", 1'b0, ZD); idle();
        oe_n = 1'b0; #1 chk("R8 async enable", 1'b1, B1);
        oe_n = 1'b1; #1 chk("R8 async disable", 1'b0, ZD);
        oe_n = 1'b0;
        @(negedge clk); drv(1'b1, 1'b0, 1'b0, '0, 8'd3, ZD);
        @(negedge clk); idle();
        @(negedge clk); chk("R8 write after dummy read", 1'b1, A1);

        // Sleep: commands blocked, contents kept, valid forced low
        @(negedge clk); sleep = 1'b1; drv(1'b1, 1'b1, 1'b0, '0, 8'd1, ONES);
        @(negedge clk); drv(1'b1, 1'b0, 1'b0, '0, 8'd1, ZD);
        @(negedge clk); chk("R9 no access in sleep", 1'b0, ZD);
        @(negedge clk); chk("R9 no access in sleep", 1'b0, ZD);
        sleep = 1'b0; drv(1'b1, 1'b0, 1'b0, '0, 8'd1, ZD);
        @(negedge clk); idle();
        @(negedge clk); chk("R9 contents kept", 1'b1, B1);
        sleep = 1'b1; #1 chk("R9 async off", 1'b0, ZD);
        sleep = 1'b0; #1 chk("R9 async back on", 1'b1, B1);

        // Reset with a word on the output
        @(negedge clk); drv(1'b1, 1'b0, 1'b0, '0, 8'd2, ZD);
        @(negedge clk); idle();
        @(negedge clk); chk("R11 before reset", 1'b1, A3);
        rst_n = 1'b0; #1 chk("R1 async reset", 1'b0, ZD);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); chk("R1 idle after reset", 1'b0, ZD);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule